// File: doc/BRIEF.md
# PHY Management Transaction Requester

This block turns one software write into one PHY management transaction. A write to the command register records a PHY address, a register address and a direction bit, and launches the transaction in the same clock edge. A separate data register supplies the 16-bit value for a PHY register write and receives the 16-bit result of a PHY register read. A busy flag stays high from the launch until the transaction ends and then clears by itself.

The bus toward the PHYs is a parallel request/acknowledge handshake, not the serial pin protocol. The requester holds a request with its fields until the addressed PHY acknowledges. With the acknowledge, the PHY side reports whether a device exists at that address. A read that reaches no device, or that gets no acknowledge within a fixed window, completes with all ones in the data register. Commands and data writes that arrive while a transaction is outstanding are dropped, so the fields on the bus and the outgoing data cannot change mid-transaction.

Top module: `phymgmt_requester`

## Requirements
- R1: A write to the command register while idle raises busy and mgmt_req on the next clock edge and starts one transaction.
- R2: Command word layout: bit 0 is the direction, bits 5:1 the PHY register address, bits 10:6 the PHY address; these fields drive mgmt_reg and mgmt_phy during the transaction and read back on addr_q.
- R3: Direction bit 1 gives a PHY register write: mgmt_we is 1 and mgmt_wdata carries the data register; direction bit 0 gives a read with mgmt_we at 0.
- R4: A read acknowledged with mgmt_present at 1 loads mgmt_rdata into the data register.
- R5: A read acknowledged with mgmt_present at 0 loads 0xFFFF into the data register.
- R6: On the edge that samples mgmt_ack with mgmt_req high, the transaction ends: busy and mgmt_req are low after that edge.
- R7: If no acknowledge arrives, the request stays high for exactly TIMEOUT_CYC (default 64) cycles and the transaction then ends; a read ended this way yields 0xFFFF, and a write ended this way leaves the data register unchanged.
- R8: A command register write while busy is ignored: the fields, direction and transaction stay unchanged and no second request follows.
- R9: A data register write while busy is ignored; the data register keeps its value.
- R10: After reset, busy, mgmt_req, addr_q and data_q are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_wr | input | 1 | Write strobe for the command register |
| addr_wdata | input | 11 | Command word (R2 layout) |
| data_wr | input | 1 | Write strobe for the data register |
| data_wdata | input | 16 | Value for the data register |
| addr_q | output | 11 | Command register readback |
| data_q | output | 16 | Data register readback |
| busy | output | 1 | Transaction outstanding |
| mgmt_req | output | 1 | Request toward the PHY side |
| mgmt_we | output | 1 | 1 = PHY register write, 0 = read |
| mgmt_phy | output | 5 | Target PHY address |
| mgmt_reg | output | 5 | Target PHY register address |
| mgmt_wdata | output | 16 | Data for a PHY register write |
| mgmt_ack | input | 1 | PHY side acknowledge |
| mgmt_rdata | input | 16 | Read data from the PHY side |
| mgmt_present | input | 1 | A device answered at the address (valid with ack) |

## Verification
The hardest case to reach is a second command or data write that lands while a transaction is still waiting for its acknowledge. A short acknowledge would end the transaction before the stray write could land. The bench's PHY model therefore answers each request after a programmed number of cycles, or never, and this keeps the request open long enough for the driver to inject conflicting writes. The model also counts how many cycles the request stays up with no answer, so the exact length of the timeout window is measured at the ports.

// File: rtl/phymgmt_pkg.sv
package phymgmt_pkg;
  localparam int PHY_AW = 5;
  localparam int REG_AW = 5;
  localparam int DATA_W = 16;
  localparam int CMD_W  = PHY_AW + REG_AW + 1;

  // Field order matches the command word: PHY address high, direction in bit 0.
  typedef struct packed {
    logic [PHY_AW-1:0] phy;
    logic [REG_AW-1:0] regn;
    logic              wr;
  } mgmt_cmd_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } mgmt_state_e;

  localparam logic [DATA_W-1:0] NO_PHY_DATA = '1;
endpackage

// File: rtl/phymgmt_rst_sync.sv
module phymgmt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/phymgmt_timeout.sv
module phymgmt_timeout #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int            CW   = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = run | (cnt_q != '0);
    cnt_d  = run ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = run & (cnt_q == LAST);
endmodule

// File: rtl/phymgmt_seq.sv
module phymgmt_seq
  import phymgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              ack,
  input  logic              present,
  input  logic [DATA_W-1:0] rdata,
  input  logic              op_wr,
  input  logic              expired,
  output logic              busy,
  output logic              req,
  output logic              timer_run,
  output logic              rd_load,
  output logic [DATA_W-1:0] rd_value
);
  mgmt_state_e state_q;
  mgmt_state_e state_d;
  logic        ack_hit;
  logic        finish;

  always_comb begin
    ack_hit  = (state_q == ST_WAIT) & ack;
    finish   = (state_q == ST_WAIT) & (ack | expired);
    rd_load  = finish & ~op_wr;
    rd_value = (ack_hit & present) ? rdata : NO_PHY_DATA;
    state_d  = state_q;
    unique case (state_q)
      ST_IDLE: if (launch) state_d = ST_WAIT;
      ST_WAIT: if (finish) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign busy      = (state_q == ST_WAIT);
  assign req       = (state_q == ST_WAIT);
  assign timer_run = (state_q == ST_WAIT) & ~ack;
endmodule

// File: rtl/phymgmt_cmd_regs.sv
module phymgmt_cmd_regs
  import phymgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [CMD_W-1:0]  addr_wdata,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_wdata,
  input  logic              busy,
  input  logic              rd_load,
  input  logic [DATA_W-1:0] rd_value,
  output mgmt_cmd_t         cmd_q,
  output logic [DATA_W-1:0] data_q
);
  mgmt_cmd_t         cmd_d;
  logic              cmd_en;
  logic [DATA_W-1:0] data_d;
  logic              data_en;

  always_comb begin
    cmd_en  = launch;
    cmd_d   = mgmt_cmd_t'(addr_wdata);
    data_en = rd_load | (data_wr & ~busy);
    data_d  = rd_load ? rd_value : data_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_en) begin
      cmd_q <= cmd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/phymgmt_requester.sv
module phymgmt_requester
  import phymgmt_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr,
  input  logic [CMD_W-1:0]  addr_wdata,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_wdata,
  output logic [CMD_W-1:0]  addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              busy,
  output logic              mgmt_req,
  output logic              mgmt_we,
  output logic [PHY_AW-1:0] mgmt_phy,
  output logic [REG_AW-1:0] mgmt_reg,
  output logic [DATA_W-1:0] mgmt_wdata,
  input  logic              mgmt_ack,
  input  logic [DATA_W-1:0] mgmt_rdata,
  input  logic              mgmt_present
);
  logic              rst_n_sync;
  logic              launch;
  logic              busy_i;
  logic              timer_run;
  logic              expired;
  logic              rd_load;
  logic [DATA_W-1:0] rd_value;
  mgmt_cmd_t         cmd;

  phymgmt_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  assign launch = addr_wr & ~busy_i;

  phymgmt_cmd_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .launch     (launch),
    .addr_wdata (addr_wdata),
    .data_wr    (data_wr),
    .data_wdata (data_wdata),
    .busy       (busy_i),
    .rd_load    (rd_load),
    .rd_value   (rd_value),
    .cmd_q      (cmd),
    .data_q     (data_q)
  );

  phymgmt_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .launch    (launch),
    .ack       (mgmt_ack),
    .present   (mgmt_present),
    .rdata     (mgmt_rdata),
    .op_wr     (cmd.wr),
    .expired   (expired),
    .busy      (busy_i),
    .req       (mgmt_req),
    .timer_run (timer_run),
    .rd_load   (rd_load),
    .rd_value  (rd_value)
  );

  phymgmt_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .run     (timer_run),
    .expired (expired)
  );

  assign busy       = busy_i;
  assign addr_q     = cmd;
  assign mgmt_we    = cmd.wr;
  assign mgmt_phy   = cmd.phy;
  assign mgmt_reg   = cmd.regn;
  assign mgmt_wdata = data_q;
endmodule

// File: rtl/phymgmt_checker.sv
module phymgmt_checker
  import phymgmt_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_wr,
  input logic              data_wr,
  input logic              busy,
  input logic              mgmt_req,
  input logic              mgmt_ack,
  input logic              mgmt_we,
  input logic              mgmt_present,
  input logic [PHY_AW-1:0] mgmt_phy,
  input logic [REG_AW-1:0] mgmt_reg,
  input logic [DATA_W-1:0] data_q
);
  int unsigned wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= 0;
    end else if (mgmt_req && !mgmt_ack) begin
      wait_cnt <= wait_cnt + 1;
    end else begin
      wait_cnt <= 0;
    end
  end

  a_r1_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_wr && !busy) |=> (busy && mgmt_req));

  a_r5_no_phy_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_req && mgmt_ack && !mgmt_we && !mgmt_present) |=> (data_q == NO_PHY_DATA));

  a_r6_ack_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_req && mgmt_ack) |=> (!busy && !mgmt_req));

  a_r7_window: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_req |-> (wait_cnt < TIMEOUT_CYC));

  a_r8_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && addr_wr) |=> ($stable(mgmt_phy) && $stable(mgmt_reg) && $stable(mgmt_we)));

  a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && data_wr && mgmt_we) |=> $stable(data_q));
endmodule

bind phymgmt_requester phymgmt_checker #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_sync),
  .addr_wr      (addr_wr),
  .data_wr      (data_wr),
  .busy         (busy),
  .mgmt_req     (mgmt_req),
  .mgmt_ack     (mgmt_ack),
  .mgmt_we      (mgmt_we),
  .mgmt_present (mgmt_present),
  .mgmt_phy     (mgmt_phy),
  .mgmt_reg     (mgmt_reg),
  .data_q       (data_q)
);

// File: tb/sim_phymgmt_requester.sv
module sim_phymgmt_requester;
  localparam int TO = 64;

  logic        clk;
  logic        rst_n;
  logic        addr_wr;
  logic [10:0] addr_wdata;
  logic        data_wr;
  logic [15:0] data_wdata;
  logic [10:0] addr_q;
  logic [15:0] data_q;
  logic        busy;
  logic        mgmt_req;
  logic        mgmt_we;
  logic [4:0]  mgmt_phy;
  logic [4:0]  mgmt_reg;
  logic [15:0] mgmt_wdata;
  logic        mgmt_ack;
  logic [15:0] mgmt_rdata;
  logic        mgmt_present;

  phymgmt_requester #(.TIMEOUT_CYC(TO)) u0 (
    .clk(clk), .rst_n(rst_n),
    .addr_wr(addr_wr), .addr_wdata(addr_wdata),
    .data_wr(data_wr), .data_wdata(data_wdata),
    .addr_q(addr_q), .data_q(data_q), .busy(busy),
    .mgmt_req(mgmt_req), .mgmt_we(mgmt_we), .mgmt_phy(mgmt_phy),
    .mgmt_reg(mgmt_reg), .mgmt_wdata(mgmt_wdata),
    .mgmt_ack(mgmt_ack), .mgmt_rdata(mgmt_rdata), .mgmt_present(mgmt_present)
  );

  typedef struct {
    logic [4:0]  phy;
    logic [4:0]  regn;
    logic        we;
    logic [15:0] wdata;
    int          delay;   // -1: never acknowledge
    logic        present;
    logic [15:0] rdata;
  } item_t;

  item_t exp_q[$];
  int    checks   = 0;
  int    failures = 0;
  bit    finished = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor / PHY model: pops expected requests and answers them.
  initial begin : phy_model
    item_t cur;
    bit    serving;
    int    reqcyc;
    int    waited;
    serving      = 0;
    reqcyc       = 0;
    waited       = 0;
    mgmt_ack     = 1'b0;
    mgmt_present = 1'b0;
    mgmt_rdata   = 16'h0BAD;
    forever begin
      @(negedge clk);
      if (mgmt_ack) begin
        mgmt_ack     = 1'b0;
        mgmt_present = 1'b0;
        mgmt_rdata   = 16'h0BAD;
        serving      = 0;
        chk(!mgmt_req && !busy, "R6", "req/busy after ack", {mgmt_req, busy}, 0);
      end else if (serving) begin
        if (!mgmt_req) begin
          serving = 0;
          chk(cur.delay < 0, "R7", "request ended without ack", cur.delay, -1);
          chk(reqcyc == TO, "R7", "cycles of unanswered request", reqcyc, TO);
        end else begin
          reqcyc++;
          waited++;
          if (cur.delay == waited) begin
            mgmt_ack     = 1'b1;
            mgmt_present = cur.present;
            mgmt_rdata   = cur.rdata;
          end
        end
      end else if (mgmt_req) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8", "unexpected request", 1, 0);
        end else begin
          cur = exp_q.pop_front();
          chk(mgmt_phy == cur.phy, "R2", "PHY address", mgmt_phy, cur.phy);
          chk(mgmt_reg == cur.regn, "R2", "register address", mgmt_reg, cur.regn);
          chk(mgmt_we == cur.we, "R3", "direction", mgmt_we, cur.we);
          if (cur.we)
            chk(mgmt_wdata == cur.wdata, "R3", "write data", mgmt_wdata, cur.wdata);
          serving = 1;
          reqcyc  = 1;
          waited  = 0;
          if (cur.delay == 0) begin
            mgmt_ack     = 1'b1;
            mgmt_present = cur.present;
            mgmt_rdata   = cur.rdata;
          end
        end
      end
    end
  end

  // Driver: one transaction, expected values computed from the requirements.
  task automatic do_txn(input logic [4:0] phy, input logic [4:0] regn, input logic wr,
                        input logic [15:0] wdata, input int delay, input logic present,
                        input logic [15:0] rdata, input bit meddle, input string req);
    item_t       it;
    logic [15:0] exp;
    int          guard;
    if (wr) exp = wdata;
    else if (delay < 0 || !present) exp = 16'hFFFF;
    else exp = rdata;

    data_wr    = 1'b1;
    data_wdata = wdata;
    @(negedge clk);
    data_wr = 1'b0;
    chk(data_q == wdata, "R9", "data write while idle", data_q, wdata);

    it.phy = phy; it.regn = regn; it.we = wr; it.wdata = wdata;
    it.delay = delay; it.present = present; it.rdata = rdata;
    exp_q.push_back(it);

    addr_wr    = 1'b1;
    addr_wdata = {phy, regn, wr};
    @(negedge clk);
    addr_wr = 1'b0;
    chk(busy && mgmt_req, "R1", "busy/req after launch", {busy, mgmt_req}, 2'b11);
    chk(addr_q == {phy, regn, wr}, "R2", "command readback", addr_q, {phy, regn, wr});

    if (meddle) begin
      repeat (2) @(negedge clk);
      addr_wr    = 1'b1;
      addr_wdata = ~{phy, regn, wr};
      data_wr    = 1'b1;
      data_wdata = ~wdata;
      @(negedge clk);
      addr_wr = 1'b0;
      data_wr = 1'b0;
      chk(mgmt_phy == phy && mgmt_reg == regn && mgmt_we == wr, "R8",
          "fields after write while busy", {mgmt_phy, mgmt_reg, mgmt_we}, {phy, regn, wr});
      chk(data_q == wdata, "R9", "data after write while busy", data_q, wdata);
    end

    guard = 0;
    while (busy && guard < 4 * TO) begin
      @(negedge clk);
      guard++;
    end
    chk(!busy, "R6", "busy cleared", busy, 0);
    chk(data_q == exp, req, "data register after transaction", data_q, exp);
    @(negedge clk);
  endtask

  initial begin : driver
    rst_n      = 1'b0;
    addr_wr    = 1'b0;
    addr_wdata = '0;
    data_wr    = 1'b0;
    data_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !mgmt_req, "R10", "busy/req after reset", {busy, mgmt_req}, 0);
    chk(addr_q == '0, "R10", "command after reset", addr_q, 0);
    chk(data_q == '0, "R10", "data after reset", data_q, 0);

    do_txn(5'd1,  5'd0,  1'b1, 16'hA5A5, 0,  1'b1, 16'h0000, 0, "R3");
    do_txn(5'd3,  5'd2,  1'b0, 16'h1111, 2,  1'b1, 16'h1234, 0, "R4");
    do_txn(5'd31, 5'd31, 1'b0, 16'h2222, 1,  1'b0, 16'h4321, 0, "R5");
    do_txn(5'd7,  5'd4,  1'b0, 16'h3333, -1, 1'b1, 16'h5555, 1, "R7");
    do_txn(5'd9,  5'd6,  1'b1, 16'h6789, -1, 1'b0, 16'h0000, 0, "R7");
    do_txn(5'd12, 5'd17, 1'b1, 16'h0F0F, 8,  1'b1, 16'h0000, 1, "R9");
    do_txn(5'd0,  5'd1,  1'b0, 16'h7777, 0,  1'b1, 16'h0000, 0, "R4");
    do_txn(5'd20, 5'd10, 1'b0, 16'h8888, 6,  1'b1, 16'hBEEF, 1, "R8");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "requests left unserved", exp_q.size(), 0);
    chk(!mgmt_req, "R8", "no extra request", mgmt_req, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule